// File: doc/BRIEF.md
# Beam-Synchronised Register List Engine

This block walks a list of two-word instructions held in memory and turns them into writes on a register port. The writes are timed against the video beam. Each instruction is read through a request/acknowledge memory port. The engine then takes one of three actions:

- It writes a 16-bit value to a register offset.
- It waits until the beam counters reach a programmed position.
- It skips the following instruction when the beam has already passed a position.

Software programs two list start addresses and a control bit through a small configuration write port. A frame-start pulse restarts execution from the first list. A write of any value to either of two strobe offsets restarts execution at once from the matching list.

Writes into the low, sensitive part of the register space are refused unless an unlock bit is set. A refused write stops the engine and raises a `halted` flag until the next restart. A wait whose position is never reached acts as the end of the list: the engine idles there until a restart. The conventional end word pair is $FFDF,$FFFE.

Top module: `beamcop`

## Requirements
- R1: A MOVE has bit 0 of word 1 equal to 0. The register byte offset is {word1[8:1],0} and the data is word 2. It appears as a single-cycle `reg_we` pulse carrying that offset and data. With an acknowledge in every cycle, instruction n of a list writes 3+3n cycles after the restart edge.
- R2: Instruction words are fetched from consecutive byte addresses: the list start, then +2, +4 and so on. `mem_req` and `mem_addr` stay unchanged until `mem_ack` is seen.
- R3: A `frame_start` pulse restarts fetching from list 1. List 1's address is {hi,lo}: hi is written at offset $080 (its low ADDR_W-16 bits are used) and lo at offset $082. List 2's address uses the same layout at $084/$086.
- R4: A configuration write of any data to offset $088 restarts from list 1, and one to $08A restarts from list 2. `frame_start` wins over a simultaneous strobe. Writing a pointer register without a strobe does not restart or disturb the engine.
- R5: A MOVE to an offset below $080 is performed only while bit 1 of the control register at offset $02E is 1. Otherwise no write occurs, `halted` rises on the cycle after that instruction's execute cycle, and the engine issues no fetch or write until a restart clears `halted`.
- R6: When word 1 bit 0 is 1 and word 2 bit 0 is 0, the instruction is a WAIT. The target position has three parts: VP = word1[15:8], HP = word1[7:1], and a compare enable for each bit (word2[14:8] for VP[6:0], word2[7:1] for HP). VP[7] is always compared. The engine resumes when {V, H[7:1]} masked is at least the masked target. The next instruction's write follows 3 cycles after the first cycle in which this holds, and no fetch happens while waiting.
- R7: When word 1 bit 0 is 1 and word 2 bit 0 is 1, the instruction is a SKIP, which uses the WAIT comparison once in its execute cycle. If the comparison is met, the next instruction is passed over without being executed. If it is not met, the next instruction executes normally.
- R8: The pair $FFDF,$FFFE stalls the engine with no fetch and no write for as long as V stays below 255.
- R9: After reset the engine is idle, with `mem_req`, `reg_we` and `halted` low, until the first restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| beam_v | input | 8 | Current vertical beam position |
| beam_h | input | 8 | Current horizontal beam position |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | Configuration write byte offset |
| cfg_wdata | input | 16 | Configuration write data |
| mem_req | output | 1 | Instruction fetch request |
| mem_addr | output | ADDR_W | Fetch byte address |
| mem_ack | input | 1 | Fetch acknowledge, with data valid in the same cycle |
| mem_rdata | input | 16 | Fetched instruction word |
| reg_we | output | 1 | Register write pulse |
| reg_addr | output | 9 | Register write byte offset |
| reg_data | output | 16 | Register write data |
| halted | output | 1 | Engine stopped by a refused protected write |

## Verification
The hardest situations to reach from the ports depend on the beam value in the exact execute cycle of a WAIT or SKIP. A comparison that lands one count either side of the target changes both which write appears and when it appears.

The bench drives the beam from a counter tied to the restart edge, so it can predict the cycle in which each wait resolves. It sweeps targets and enable masks, including vertical-only and horizontal-only compares. For the skip cases it holds the beam still at values equal to, just below and just above the target.

The protection halt is reached with three list/control combinations:
- a list that writes $080 and then $07E;
- a control word with every bit set except the unlock bit;
- the unlock bit alone.

// File: rtl/beamcop_pkg.sv
// Shared types and register offsets for the beam-synchronised list engine.
// Assumes 16-bit instruction words and a 9-bit register byte-offset space.
package beamcop_pkg;

    localparam int WORD_W = 16;
    localparam int OFS_W  = 9;

    localparam logic [OFS_W-1:0] OFS_CTRL  = 9'h02E;
    localparam logic [OFS_W-1:0] OFS_L1_HI = 9'h080;
    localparam logic [OFS_W-1:0] OFS_L1_LO = 9'h082;
    localparam logic [OFS_W-1:0] OFS_L2_HI = 9'h084;
    localparam logic [OFS_W-1:0] OFS_L2_LO = 9'h086;
    localparam logic [OFS_W-1:0] OFS_GO1   = 9'h088;
    localparam logic [OFS_W-1:0] OFS_GO2   = 9'h08A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH1,
        ST_FETCH2,
        ST_EXEC,
        ST_HALT
    } state_t;

    typedef enum logic [1:0] {
        OP_MOVE,
        OP_WAIT,
        OP_SKIP
    } op_t;

    typedef struct packed {
        op_t               op;
        logic [OFS_W-1:0]  dest;
        logic [WORD_W-1:0] target;
        logic [WORD_W-1:0] mask;
    } instr_t;

endpackage

// File: rtl/beamcop_regs.sv
// Configuration registers: two list start addresses, the unlock control bit,
// and the two restart strobes decoded from the configuration write port.
// Assumes ADDR_W lies between 17 and 32 bits.
module beamcop_regs
    import beamcop_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OFS_W-1:0]  cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] list1_ptr,
    output logic [ADDR_W-1:0] list2_ptr,
    output logic              unlock,
    output logic              go1,
    output logic              go2
);
    localparam int HI_W = ADDR_W - WORD_W;

    logic [HI_W-1:0]   hi1_q, hi2_q;
    logic [WORD_W-1:0] lo1_q, lo2_q;
    logic              unlock_q;

    // Capture configuration writes into the pointer halves and control bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi1_q    <= '0;
            lo1_q    <= '0;
            hi2_q    <= '0;
            lo2_q    <= '0;
            unlock_q <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                OFS_L1_HI: hi1_q    <= cfg_wdata[HI_W-1:0];
                OFS_L1_LO: lo1_q    <= cfg_wdata;
                OFS_L2_HI: hi2_q    <= cfg_wdata[HI_W-1:0];
                OFS_L2_LO: lo2_q    <= cfg_wdata;
                OFS_CTRL:  unlock_q <= cfg_wdata[1];
                default:   ;
            endcase
        end
    end

    // Strobes act in the cycle of the write; the data is ignored.
    always_comb begin
        go1 = cfg_we && (cfg_addr == OFS_GO1);
        go2 = cfg_we && (cfg_addr == OFS_GO2);
    end

    assign list1_ptr = {hi1_q, lo1_q};
    assign list2_ptr = {hi2_q, lo2_q};
    assign unlock    = unlock_q;

endmodule

// File: rtl/beamcop_decode.sv
// Splits a fetched word pair into operation, destination and beam target.
// Assumes word 2 bit 15 carries no compare meaning (only MOVE data uses it).
module beamcop_decode
    import beamcop_pkg::*;
(
    input  logic [WORD_W-1:0] w1,
    input  logic [14:0]       w2_lo,
    output instr_t            instr
);
    // Classify the pair and form target and compare-enable vectors.
    always_comb begin
        if (!w1[0])
            instr.op = OP_MOVE;
        else if (w2_lo[0])
            instr.op = OP_SKIP;
        else
            instr.op = OP_WAIT;
        instr.dest   = {w1[8:1], 1'b0};
        instr.target = {w1[15:8], w1[7:1], 1'b0};
        instr.mask   = {1'b1, w2_lo[14:8], w2_lo[7:1], 1'b0};
    end

endmodule

// File: rtl/beamcop_cmp.sv
// Beam position comparator: vertical position is the more significant part,
// horizontal the less; both sides are masked by the compare enables first.
module beamcop_cmp
    import beamcop_pkg::*;
(
    input  logic [7:0]        beam_v,
    input  logic [7:0]        beam_h,
    input  logic [WORD_W-1:0] target,
    input  logic [WORD_W-1:0] mask,
    output logic              reached
);
    logic [WORD_W-1:0] beam_pos;

    // Masked greater-or-equal comparison of beam against target.
    always_comb begin
        beam_pos = {beam_v, beam_h};
        reached  = (beam_pos & mask) >= (target & mask);
    end

endmodule

// File: rtl/beamcop.sv
// Beam-synchronised register list engine: fetches two-word instructions,
// issues register writes, waits on or skips by beam position, and restarts
// on frame start or strobe. Assumes mem_ack only arrives while mem_req is
// high, with mem_rdata valid in the same cycle.
module beamcop
    import beamcop_pkg::*;
#(
    parameter int               ADDR_W     = 20,
    parameter logic [OFS_W-1:0] PROT_LIMIT = 9'h080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [7:0]        beam_v,
    input  logic [7:0]        beam_h,
    input  logic              cfg_we,
    input  logic [OFS_W-1:0]  cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              reg_we,
    output logic [OFS_W-1:0]  reg_addr,
    output logic [WORD_W-1:0] reg_data,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(4);

    state_t            state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [WORD_W-1:0] w1_q, w2_q;
    logic [ADDR_W-1:0] list1_ptr, list2_ptr, start_ptr;
    logic              unlock, go1, go2, restart, reached, blocked;
    instr_t            instr;

    beamcop_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .list1_ptr (list1_ptr),
        .list2_ptr (list2_ptr),
        .unlock    (unlock),
        .go1       (go1),
        .go2       (go2)
    );

    beamcop_decode u_decode (
        .w1    (w1_q),
        .w2_lo (w2_q[14:0]),
        .instr (instr)
    );

    beamcop_cmp u_cmp (
        .beam_v  (beam_v),
        .beam_h  (beam_h),
        .target  (instr.target),
        .mask    (instr.mask),
        .reached (reached)
    );

    // Restart source selection: frame start beats a strobe.
    always_comb begin
        restart   = frame_start || go1 || go2;
        start_ptr = (frame_start || go1) ? list1_ptr : list2_ptr;
        blocked   = (instr.dest < PROT_LIMIT) && !unlock;
    end

    // Sequencer: fetch two words, then execute, wait or halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            w1_q    <= '0;
            w2_q    <= '0;
        end else if (restart) begin
            state_q <= ST_FETCH1;
            pc_q    <= start_ptr;
        end else begin
            case (state_q)
                ST_FETCH1: if (mem_ack) begin
                    w1_q    <= mem_rdata;
                    pc_q    <= pc_q + STEP1;
                    state_q <= ST_FETCH2;
                end
                ST_FETCH2: if (mem_ack) begin
                    w2_q    <= mem_rdata;
                    pc_q    <= pc_q + STEP1;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    case (instr.op)
                        OP_MOVE: state_q <= blocked ? ST_HALT : ST_FETCH1;
                        OP_WAIT: if (reached) state_q <= ST_FETCH1;
                        default: begin
                            if (reached) pc_q <= pc_q + STEP2;
                            state_q <= ST_FETCH1;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Port outputs decoded from the sequencer state.
    always_comb begin
        mem_req  = (state_q == ST_FETCH1) || (state_q == ST_FETCH2);
        mem_addr = pc_q;
        reg_we   = (state_q == ST_EXEC) && (instr.op == OP_MOVE) && !blocked;
        reg_addr = instr.dest;
        reg_data = w2_q;
        halted   = (state_q == ST_HALT);
    end

    // R5: a write below the protection limit only happens while unlocked.
    assert_prot_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr < PROT_LIMIT)) |-> unlock);

    // R5: once halted, no fetch and no write until a restart.
    assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !restart) |=> (halted && !reg_we && !mem_req));

    // R2: an unacknowledged request holds its address.
    assert_hold_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !restart) |=> (mem_req && $stable(mem_addr)));

    // R3: frame start fetches from list 1 on the next cycle.
    assert_frame_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (mem_req && (mem_addr == $past(list1_ptr))));

    // R6: an unmet wait issues no fetch in the following cycle.
    assert_wait_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EXEC) && (instr.op == OP_WAIT) && !reached && !restart)
        |=> !mem_req);

endmodule

// File: tb/beamcop_bench.sv
module beamcop_bench;
    localparam int AW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [7:0]  beam_v = '0, beam_h = '0;
    logic        cfg_we = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        mem_req, mem_ack, reg_we, halted;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_rdata, reg_data;
    logic [8:0]  reg_addr;

    logic [15:0] mem [0:255];
    logic        ack_gate = 1'b1;
    bit          ack_slow = 1'b0;
    bit          beam_free = 1'b1;
    bit          done = 1'b0;
    int          cnt = 0, fs_cnt = 0, beam_base = 0;
    int          n_chk = 0, n_fail = 0;
    int          n_wr = 0, n_fx = 0, halt_rel = -1;
    int          wr_addr [0:63];
    int          wr_data [0:63];
    int          wr_rel  [0:63];
    int          fx_addr [0:63];

    always #2 clk = ~clk;

    assign mem_ack   = mem_req & ack_gate;
    assign mem_rdata = mem[mem_addr[8:1]];

    beamcop u_beamcop (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .beam_v(beam_v), .beam_h(beam_h),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_data(reg_data), .halted(halted)
    );

    // Negedge monitor: beam script, ack pattern, write and fetch logs.
    always @(negedge clk) begin
        int rel;
        cnt = cnt + 1;
        if (beam_free) begin
            rel = cnt - beam_base;
            beam_h = 8'(rel % 40);
            beam_v = 8'((rel / 40) % 200);
        end
        ack_gate = ack_slow ? ~ack_gate : 1'b1;
        if (reg_we && n_wr < 64) begin
            wr_addr[n_wr] = int'(reg_addr);
            wr_data[n_wr] = int'(reg_data);
            wr_rel[n_wr]  = cnt - fs_cnt;
            n_wr++;
        end
        if (mem_req && ack_gate && n_fx < 64) begin
            fx_addr[n_fx] = int'(mem_addr);
            n_fx++;
        end
        if (halted && halt_rel < 0) halt_rel = cnt - fs_cnt;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // kind 0: frame, 1: strobe $088, 2: strobe $08A, 3: frame plus strobe $08A
    task automatic kick(input int kind, input logic [15:0] d);
        @(negedge clk); #1;
        fs_cnt = cnt; beam_base = cnt;
        n_wr = 0; n_fx = 0; halt_rel = -1;
        frame_start = (kind == 0 || kind == 3);
        cfg_we      = (kind != 0);
        cfg_addr    = (kind == 1) ? 9'h088 : 9'h08A;
        cfg_wdata   = d;
        @(negedge clk); #1;
        frame_start = 1'b0; cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] mv(input logic [8:0] dst, input logic [15:0] d);
        return {7'b0, dst[8:1], 1'b0, d};
    endfunction

    function automatic logic [31:0] cmpw(input logic [7:0] v, input logic [7:0] h,
                                         input logic [6:0] vm, input logic [6:0] hm,
                                         input logic skip);
        return {v, h[7:1], 1'b1, 1'b1, vm, hm, skip};
    endfunction

    task automatic put(input int idx, input logic [31:0] ins);
        mem[idx] = ins[31:16];
        mem[idx+1] = ins[15:0];
    endtask

    function automatic bit beam_ge(input int rel, input logic [7:0] tv, input logic [7:0] th,
                                   input logic [6:0] vm, input logic [6:0] hm);
        logic [7:0] bv, bh;
        logic [14:0] a, b;
        bv = 8'((rel / 40) % 200);
        bh = 8'(rel % 40);
        a = {bv[7], bv[6:0] & vm, bh[7:1] & hm};
        b = {tv[7], tv[6:0] & vm, th[7:1] & hm};
        return a >= b;
    endfunction

    function automatic int wait_end(input logic [7:0] tv, input logic [7:0] th,
                                    input logic [6:0] vm, input logic [6:0] hm);
        for (int r = 6; r < 8000; r++)
            if (beam_ge(r, tv, th, vm, hm)) return r;
        return -1;
    endfunction

    task automatic clear_mem;
        for (int i = 0; i < 256; i += 2) put(i, 32'hFFDF_FFFE);
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    logic [7:0] tv_set [0:2] = '{8'd0, 8'd1, 8'd3};
    logic [7:0] th_set [0:3] = '{8'h00, 8'h0C, 8'h1F, 8'h26};

    initial begin
        clear_mem();
        run(3);
        @(negedge clk); #1 rst_n = 1'b1;
        run(12);
        // R9: idle after reset
        chk("R9 mem_req idle", int'(mem_req), 0);
        chk("R9 no writes", n_wr, 0);
        chk("R9 halted low", int'(halted), 0);

        // R1 R3 R8: plain MOVE list ending in the end marker
        put(0, mv(9'h180, 16'h1111));
        put(2, mv(9'h182, 16'h2222));
        put(4, mv(9'h1FE, 16'hABCD));
        put(6, mv(9'h0A0, 16'h5A5A));
        kick(0, 16'h0);
        run(40);
        chk("R1 write count", n_wr, 4);
        chk("R1 addr0", wr_addr[0], 'h180); chk("R1 data0", wr_data[0], 'h1111);
        chk("R1 addr2", wr_addr[2], 'h1FE); chk("R1 data2", wr_data[2], 'hABCD);
        chk("R1 addr3", wr_addr[3], 'h0A0); chk("R1 data3", wr_data[3], 'h5A5A);
        for (int i = 0; i < 4; i++) chk("R1 write timing", wr_rel[i], 3 + 3 * i);
        chk("R3 first fetch at list1", fx_addr[0], 0);
        run(300);
        // R8: stalled on the end marker
        chk("R8 no further writes", n_wr, 4);
        chk("R8 fetch count", n_fx, 10);
        chk("R8 mem_req low", int'(mem_req), 0);

        // R2: slow acknowledge keeps order and consecutive addresses
        ack_slow = 1'b1;
        kick(0, 16'h0);
        run(80);
        ack_slow = 1'b0;
        chk("R2 write count slow", n_wr, 4);
        chk("R2 data order", wr_data[1], 'h2222);
        for (int k = 0; k < 10; k++) chk("R2 fetch address", fx_addr[k], 2 * k);

        // R3: high pointer half forms the upper address bits
        host_wr(9'h080, 16'h0001);
        kick(0, 16'h0);
        run(40);
        chk("R3 high half", fx_addr[0], 'h10000);
        chk("R3 high half second word", fx_addr[1], 'h10002);
        host_wr(9'h080, 16'h0000);

        // R6: WAIT sweep over targets and compare-enable masks
        for (int m = 0; m < 3; m++) begin
            for (int a = 0; a < 3; a++) begin
                for (int b = 0; b < 4; b++) begin
                    logic [6:0] vm, hm;
                    int t;
                    vm = (m == 1) ? 7'h00 : 7'h7F;
                    hm = (m == 2) ? 7'h00 : 7'h7F;
                    clear_mem();
                    put(0, mv(9'h180, 16'h0001));
                    put(2, cmpw(tv_set[a], th_set[b], vm, hm, 1'b0));
                    put(4, mv(9'h182, 16'h0002));
                    t = wait_end(tv_set[a], th_set[b], vm, hm);
                    kick(0, 16'h0);
                    run(t + 12);
                    chk("R6 writes after wait", n_wr, 2);
                    chk("R6 resume timing", wr_rel[1], t + 3);
                end
            end
        end

        // R7: SKIP with a held beam at V=5, H=$10
        beam_free = 1'b0;
        @(negedge clk); #1 beam_v = 8'd5; beam_h = 8'h10;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] v, h;
            bit met;
            v   = (c == 0) ? 8'd4 : (c == 3) ? 8'd6 : 8'd5;
            h   = (c == 0) ? 8'h30 : (c == 2) ? 8'h12 : (c == 3) ? 8'h00 : 8'h10;
            met = (c < 2);
            clear_mem();
            put(0, cmpw(v, h, 7'h7F, 7'h7F, 1'b1));
            put(2, mv(9'h180, 16'h000A));
            put(4, mv(9'h182, 16'h000B));
            kick(0, 16'h0);
            run(30);
            chk("R7 write count", n_wr, met ? 1 : 2);
            chk("R7 first write", wr_data[0], met ? 'hB : 'hA);
            chk("R7 first write time", wr_rel[0], 6);
        end
        beam_free = 1'b1;

        // R5: protected writes
        clear_mem();
        put(0, mv(9'h080, 16'h0007));
        put(2, mv(9'h07E, 16'h0008));
        put(4, mv(9'h182, 16'h0009));
        host_wr(9'h02E, 16'h0000);
        kick(0, 16'h0);
        run(40);
        chk("R5 boundary write", n_wr, 1);
        chk("R5 boundary addr", wr_addr[0], 'h080);
        chk("R5 halted", int'(halted), 1);
        chk("R5 halt timing", halt_rel, 7);
        chk("R5 no fetch after halt", n_fx, 4);
        host_wr(9'h02E, 16'hFFFD);
        kick(0, 16'h0);
        run(3);
        chk("R5 restart clears halt", int'(halted), 0);
        run(37);
        chk("R5 other bits do not unlock", n_wr, 1);
        chk("R5 halted again", int'(halted), 1);
        host_wr(9'h02E, 16'h0002);
        kick(0, 16'h0);
        run(40);
        chk("R5 unlocked writes", n_wr, 3);
        chk("R5 protected addr", wr_addr[1], 'h07E);
        chk("R5 protected data", wr_data[1], 'h0008);
        chk("R5 not halted", int'(halted), 0);

        // R4: strobes, priority and pointer writes without strobe
        clear_mem();
        put(0, mv(9'h190, 16'h1001));
        put(64, mv(9'h1A0, 16'h2002));
        host_wr(9'h086, 16'h0080);
        kick(2, 16'h0000);
        run(30);
        chk("R4 list2 write", wr_addr[0], 'h1A0);
        chk("R4 list2 time", wr_rel[0], 3);
        chk("R4 list2 fetch", fx_addr[0], 'h80);
        kick(1, 16'hFFFF);
        run(30);
        chk("R4 list1 write", wr_addr[0], 'h190);
        chk("R4 list1 time", wr_rel[0], 3);
        kick(3, 16'h1234);
        run(30);
        chk("R4 frame beats strobe", wr_addr[0], 'h190);
        chk("R4 one write", n_wr, 1);
        fs_cnt = cnt; n_wr = 0; n_fx = 0;
        host_wr(9'h086, 16'h0000);
        host_wr(9'h082, 16'h0080);
        run(30);
        chk("R4 pointer write no restart", n_fx, 0);
        chk("R4 pointer write no write", n_wr, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule